// File: doc/BRIEF.md
# Buffered SPI Master with Clock-Domain Crossing

This block is an SPI master clocked by its own peripheral clock, which is independent of the host that feeds it. The host puts a byte on `host_wdata` and pulses `host_wr`. It collects received bytes from `host_rdata` and acknowledges them with a pulse on `host_rd`. Neither strobe is related to the peripheral clock. Each strobe passes through a two-flop synchroniser and an edge detector, so that one host edge becomes exactly one single-cycle pulse inside the block.

A one-entry holding register sits in front of the shift register. While one character is on the wire, the host may queue the next byte. If the queued byte is present when the current character ends, the select line stays low and the next character follows without a break. The block supports all four clock polarity and phase combinations, MSB-first or LSB-first order, and a power-of-two SCK rate.

The status outputs report an empty holding register, a sticky overflow error and a sticky received-character flag.

The transfer engine is a four-state machine:
- **ST_IDLE**: the select line is high and SCK rests at its idle level. If the holding register is full, it loads the shift register and moves to ST_LEAD.
- **ST_LEAD**: one half period later, SCK makes its leading edge. The state then moves to ST_TRAIL.
- **ST_TRAIL**: one half period later, SCK makes its trailing edge. The state returns to ST_LEAD for the next bit, or moves to ST_GAP after the last bit.
- **ST_GAP**: this state holds for one half period. It then either reloads from the holding register and goes back to ST_LEAD with select still low, or releases select and returns to ST_IDLE.

Top module: `spi_master_cdc`

## Requirements
- R1: While `rst` is high (asynchronous, active high), and immediately after it falls:
  - `ss_n` is 1 and `sck` equals `spi_mode[1]`.
  - `tx_empty` is 1.
  - `send_err` and `rx_valid` are 0.
  - `host_rdata` is 0.
- R2: `spi_mode[1]` is the idle SCK level (CPOL). `spi_mode[0]` is the phase (CPHA):
  - CPHA = 0: MOSI is valid before the leading SCK edge and MISO is sampled on the leading edge.
  - CPHA = 1: MOSI changes on the leading edge and MISO is sampled on the trailing edge.
  - SCK is at its idle level whenever `ss_n` is high.
- R3: With `lsb_first` = 0, bit 7 goes out first on MOSI and the first bit received lands in bit 7. With `lsb_first` = 1, bit 0 goes first in both directions.
- R4: Each SCK half period lasts 2^`div_sel` peripheral clocks. A lone character holds `ss_n` low for exactly 17·2^`div_sel` clocks (16 half periods plus one closing half period).
- R5: If a byte is waiting in the holding register when a character's closing half period ends, `ss_n` stays low and the next character starts. Otherwise `ss_n` returns high.
- R6: Each active edge of `host_wr`, `host_rd` or `err_clr` acts exactly once, however long the strobe is held. The active edge of `host_wr` and `host_rd` is rising by default; a parameter selects the falling edge for each.
- R7: `tx_empty` is 1 exactly when the holding register holds no byte. A write is accepted if the register is empty or is being emptied in the same cycle.
- R8: A write that arrives while the holding register is full is discarded and sets `send_err`. `send_err` stays set and does not alter any transfer.
- R9: A rising edge of `err_clr` clears `send_err`. A simultaneous overflow takes precedence.
- R10: `rx_valid` becomes 1 when a character completes. It stays 1 through later transfers until a `host_rd` edge clears it.
- R11: `host_rdata` always shows the most recently completed character, even if the previous one was never read.
- R12: If a character completes in the same peripheral cycle as a read pulse, `rx_valid` is left at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Peripheral clock |
| rst | input | 1 | Asynchronous reset, active high |
| host_wdata | input | 8 | Byte to transmit, held stable around the write strobe |
| host_wr | input | 1 | Asynchronous write strobe |
| host_rd | input | 1 | Asynchronous read-acknowledge strobe |
| host_rdata | output | 8 | Last completed received character |
| tx_empty | output | 1 | Holding register is empty |
| send_err | output | 1 | Sticky overflow flag |
| err_clr | input | 1 | Asynchronous clear strobe for send_err |
| rx_valid | output | 1 | Sticky received-character flag |
| div_sel | input | 3 | SCK half period is 2^div_sel clocks |
| lsb_first | input | 1 | 1: LSB first, 0: MSB first |
| spi_mode | input | 2 | [1] idle SCK level, [0] sampling phase |
| sck | output | 1 | SPI serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Slave select, active low |

## Verification
The synchronised read pulse can clear `rx_valid` in the very cycle in which the final trailing edge of a character sets it. The outcome then depends on which of the two updates wins. To provoke this, the bench launches one character at the fastest rate and delays the read strobe by a sweep of cycle offsets that straddle the completion cycle. An assertion at the flag register requires that a cycle carrying both events leaves the flag set. At the ends of the sweep, the bench requires the flag set for a read clearly before completion and clear for a read clearly after it. It also requires the new byte on `host_rdata` at every offset.

// File: rtl/spi_cdc_pkg.sv
`timescale 1ns/1ps
package spi_cdc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TRAIL = 2'd2,
        ST_GAP   = 2'd3
    } xfer_state_t;

endpackage

// File: rtl/spi_edge_sync.sv
`timescale 1ns/1ps
module spi_edge_sync #(
    parameter int STAGES      = 2,
    parameter bit ACTIVE_FALL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic pulse
);

    logic [STAGES-1:0] sync_q;
    logic              hist_q;
    logic              level;

    assign level = sync_q[STAGES-1];

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            sync_q <= '0;
            hist_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_in};
            hist_q <= level;
        end
    end

    generate
        if (ACTIVE_FALL) begin : g_fall
            assign pulse = hist_q & ~level;
        end else begin : g_rise
            assign pulse = ~hist_q & level;
        end
    endgenerate

    // R6
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

endmodule

// File: rtl/spi_clk_div.sv
`timescale 1ns/1ps
module spi_clk_div #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);

    localparam int CNT_W = (1 << SEL_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    assign limit = (CNT_W'(1) << div_sel) - CNT_W'(1);
    assign tick  = run && (cnt_q >= limit);

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/spi_shift_fsm.sv
`timescale 1ns/1ps
module spi_shift_fsm
    import spi_cdc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              lsb_first,
    input  logic              buf_full,
    input  logic [DATA_W-1:0] buf_data,
    output logic              take,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic              ss_n,
    output logic              running,
    output logic              char_done,
    output logic [DATA_W-1:0] rx_word
);

    localparam int BIT_W = $clog2(DATA_W);

    xfer_state_t       state_q, state_d;
    logic [BIT_W-1:0]  bit_q;
    logic [DATA_W-1:0] tx_sr, rx_sr, rx_in, tx_next;
    logic              act_q, ss_q, done_q, last_bit;

    assign last_bit = (bit_q == BIT_W'(DATA_W - 1));
    assign rx_in    = lsb_first ? {miso, rx_sr[DATA_W-1:1]} : {rx_sr[DATA_W-2:0], miso};
    assign tx_next  = lsb_first ? {1'b0, tx_sr[DATA_W-1:1]} : {tx_sr[DATA_W-2:0], 1'b0};
    assign take     = ((state_q == ST_IDLE) && buf_full) ||
                      ((state_q == ST_GAP) && tick && buf_full);

    assign sck       = cpol ^ act_q;
    assign mosi      = lsb_first ? tx_sr[0] : tx_sr[DATA_W-1];
    assign ss_n      = ss_q;
    assign running   = (state_q != ST_IDLE);
    assign char_done = done_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (buf_full) state_d = ST_LEAD;
            ST_LEAD:  if (tick)     state_d = ST_TRAIL;
            ST_TRAIL: if (tick)     state_d = last_bit ? ST_GAP : ST_LEAD;
            ST_GAP:   if (tick)     state_d = buf_full ? ST_LEAD : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            bit_q   <= '0;
            tx_sr   <= '0;
            rx_sr   <= '0;
            rx_word <= '0;
            act_q   <= 1'b0;
            ss_q    <= 1'b1;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (take) begin
                tx_sr <= buf_data;
                bit_q <= '0;
                act_q <= 1'b0;
                ss_q  <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_IDLE: ss_q <= 1'b1;
                    ST_LEAD: if (tick) begin
                        act_q <= 1'b1;
                        if (!cpha)              rx_sr <= rx_in;
                        else if (bit_q != '0)   tx_sr <= tx_next;
                    end
                    ST_TRAIL: if (tick) begin
                        act_q <= 1'b0;
                        if (cpha)               rx_sr <= rx_in;
                        if (!cpha && !last_bit) tx_sr <= tx_next;
                        if (last_bit) begin
                            done_q  <= 1'b1;
                            rx_word <= cpha ? rx_in : rx_sr;
                        end else begin
                            bit_q <= bit_q + BIT_W'(1);
                        end
                    end
                    ST_GAP: if (tick) ss_q <= 1'b1;
                endcase
            end
        end
    end

    // R2
    sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ss_n |-> (sck == cpol));

    // R5
    ss_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ss_n) |-> !$past(buf_full));

endmodule

// File: rtl/spi_master_cdc.sv
`timescale 1ns/1ps
module spi_master_cdc #(
    parameter int DATA_W      = 8,
    parameter int SEL_W       = 3,
    parameter int SYNC_STAGES = 2,
    parameter bit WR_ON_FALL  = 1'b0,
    parameter bit RD_ON_FALL  = 1'b0
) (
    input  logic              pclk,
    input  logic              rst,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_wr,
    input  logic              host_rd,
    output logic [DATA_W-1:0] host_rdata,
    output logic              tx_empty,
    output logic              send_err,
    input  logic              err_clr,
    output logic              rx_valid,
    input  logic [SEL_W-1:0]  div_sel,
    input  logic              lsb_first,
    input  logic [1:0]        spi_mode,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              ss_n
);

    logic              wr_pulse, rd_pulse, clr_pulse;
    logic              tick, running, take, char_done, ovf;
    logic              buf_full_q, err_q, rxv_q;
    logic [DATA_W-1:0] buf_data_q;

    spi_edge_sync #(.STAGES(SYNC_STAGES), .ACTIVE_FALL(WR_ON_FALL)) u_wr_sync (
        .clk(pclk), .rst(rst), .async_in(host_wr), .pulse(wr_pulse));

    spi_edge_sync #(.STAGES(SYNC_STAGES), .ACTIVE_FALL(RD_ON_FALL)) u_rd_sync (
        .clk(pclk), .rst(rst), .async_in(host_rd), .pulse(rd_pulse));

    spi_edge_sync #(.STAGES(SYNC_STAGES), .ACTIVE_FALL(1'b0)) u_clr_sync (
        .clk(pclk), .rst(rst), .async_in(err_clr), .pulse(clr_pulse));

    spi_clk_div #(.SEL_W(SEL_W)) u_div (
        .clk(pclk), .rst(rst), .run(running), .div_sel(div_sel), .tick(tick));

    spi_shift_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(pclk), .rst(rst), .tick(tick),
        .cpol(spi_mode[1]), .cpha(spi_mode[0]), .lsb_first(lsb_first),
        .buf_full(buf_full_q), .buf_data(buf_data_q), .take(take),
        .miso(miso), .sck(sck), .mosi(mosi), .ss_n(ss_n),
        .running(running), .char_done(char_done), .rx_word(host_rdata));

    assign ovf = wr_pulse && buf_full_q && !take;

    always_ff @(posedge pclk or posedge rst) begin
        if (rst) begin
            buf_full_q <= 1'b0;
            buf_data_q <= '0;
        end else begin
            if (take) buf_full_q <= 1'b0;
            if (wr_pulse && (!buf_full_q || take)) begin
                buf_full_q <= 1'b1;
                buf_data_q <= host_wdata;
            end
        end
    end

    always_ff @(posedge pclk or posedge rst) begin
        if (rst) begin
            err_q <= 1'b0;
            rxv_q <= 1'b0;
        end else begin
            if (ovf)            err_q <= 1'b1;
            else if (clr_pulse) err_q <= 1'b0;
            if (char_done)      rxv_q <= 1'b1;
            else if (rd_pulse)  rxv_q <= 1'b0;
        end
    end

    assign tx_empty = !buf_full_q;
    assign send_err = err_q;
    assign rx_valid = rxv_q;

    // R8
    ovf_sticky_chk: assert property (@(posedge pclk) disable iff (rst)
        ovf |=> send_err);

    // R9
    err_clear_chk: assert property (@(posedge pclk) disable iff (rst)
        (clr_pulse && !ovf) |=> !send_err);

    // R12
    rx_collide_chk: assert property (@(posedge pclk) disable iff (rst)
        (rd_pulse && char_done) |=> rx_valid);

    // R7
    buf_fill_chk: assert property (@(posedge pclk) disable iff (rst)
        (wr_pulse && tx_empty) |=> !tx_empty);

endmodule

// File: tb/spi_master_cdc_tb.sv
`timescale 1ns/1ps
module spi_master_cdc_tb;

    typedef struct packed {
        logic [1:0] mode;
        logic       lsb;
        logic [2:0] div;
        logic       inv;
        logic [7:0] data;
    } vec_t;

    localparam vec_t VEC [0:5] = '{
        '{2'd0, 1'b0, 3'd0, 1'b0, 8'hA5},
        '{2'd1, 1'b1, 3'd1, 1'b1, 8'h3C},
        '{2'd2, 1'b0, 3'd2, 1'b0, 8'h81},
        '{2'd3, 1'b1, 3'd0, 1'b0, 8'h4E},
        '{2'd0, 1'b1, 3'd1, 1'b1, 8'hD2},
        '{2'd3, 1'b0, 3'd3, 1'b1, 8'h17}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] host_wdata = 8'h00;
    logic       host_wr = 1'b0, host_rd = 1'b0, err_clr = 1'b0;
    logic [7:0] host_rdata;
    logic       tx_empty, send_err, rx_valid;
    logic [2:0] div_sel = 3'd0;
    logic       lsb_first = 1'b0;
    logic [1:0] spi_mode = 2'd0;
    logic       sck, mosi, miso, ss_n;
    logic       inv = 1'b0;

    int n_chk = 0, n_fail = 0;
    int ss_rises = 0, low_cnt = 0;
    int slv_bits = 0, slv_n = 0;
    logic [7:0] slv_sr = 8'h00;
    logic [7:0] slv_bytes [0:63];
    logic       prev_sck = 1'b0;

    always #2.5 clk = ~clk;

    assign miso = mosi ^ inv;

    spi_master_cdc u_dut (
        .pclk(clk), .rst(rst), .host_wdata(host_wdata), .host_wr(host_wr),
        .host_rd(host_rd), .host_rdata(host_rdata), .tx_empty(tx_empty),
        .send_err(send_err), .err_clr(err_clr), .rx_valid(rx_valid),
        .div_sel(div_sel), .lsb_first(lsb_first), .spi_mode(spi_mode),
        .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n));

    // Independent slave: samples MOSI on the edge the mode calls for.
    always @(sck or ss_n) begin
        if (ss_n !== 1'b0) begin
            slv_bits = 0;
        end else if (sck !== prev_sck && sck == (spi_mode[1] == spi_mode[0])) begin
            slv_sr = lsb_first ? {mosi, slv_sr[7:1]} : {slv_sr[6:0], mosi};
            slv_bits = slv_bits + 1;
            if (slv_bits == 8) begin
                slv_bytes[slv_n[5:0]] = slv_sr;
                slv_n = slv_n + 1;
                slv_bits = 0;
            end
        end
        prev_sck = sck;
    end

    always @(posedge ss_n) ss_rises = ss_rises + 1;
    always @(posedge clk) if (ss_n === 1'b0) low_cnt = low_cnt + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_wr(input logic [7:0] d);
        host_wdata = d;
        #1.7 host_wr = 1'b1;
        #23.3 host_wr = 1'b0;
        #13;
    endtask

    task automatic pulse_rd();
        #1.7 host_rd = 1'b1;
        #23.3 host_rd = 1'b0;
        #13;
    endtask

    task automatic pulse_clr();
        #1.3 err_clr = 1'b1;
        #22.1 err_clr = 1'b0;
        #13;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_ss_high();
        while (ss_n !== 1'b1) @(posedge clk);
        settle(4);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        #12.3 rst = 1'b0;
        settle(3);
        // R1: reset state
        check(ss_n == 1'b1,        "R1 ss_n",       ss_n, 1);
        check(sck == 1'b0,         "R1 sck idle",   sck, 0);
        check(tx_empty == 1'b1,    "R1 tx_empty",   tx_empty, 1);
        check(send_err == 1'b0,    "R1 send_err",   send_err, 0);
        check(rx_valid == 1'b0,    "R1 rx_valid",   rx_valid, 0);
        check(host_rdata == 8'h00, "R1 host_rdata", host_rdata, 0);

        // Table walk: R2 modes, R3 bit order, R4 timing, R6 single action, R10 flag
        foreach (VEC[i]) begin
            int lc0, sn0;
            spi_mode = VEC[i].mode; lsb_first = VEC[i].lsb;
            div_sel = VEC[i].div; inv = VEC[i].inv;
            settle(3);
            check(sck == VEC[i].mode[1], "R2 idle level", sck, VEC[i].mode[1]);
            lc0 = low_cnt; sn0 = slv_n;
            pulse_wr(VEC[i].data);
            while (rx_valid !== 1'b1) @(posedge clk);
            wait_ss_high();
            check(slv_n - sn0 == 1, "R6 one char per edge", slv_n - sn0, 1);
            check(slv_bytes[sn0[5:0]] == VEC[i].data, "R2/R3 mosi byte",
                  slv_bytes[sn0[5:0]], VEC[i].data);
            check(host_rdata == (VEC[i].data ^ {8{VEC[i].inv}}), "R3 rx byte",
                  host_rdata, VEC[i].data ^ {8{VEC[i].inv}});
            check(low_cnt - lc0 == (17 << VEC[i].div), "R4 ss low cycles",
                  low_cnt - lc0, 17 << VEC[i].div);
            check(tx_empty == 1'b1, "R7 empty after send", tx_empty, 1);
            check(rx_valid == 1'b1, "R10 flag set", rx_valid, 1);
            pulse_rd();
            settle(3);
            check(rx_valid == 1'b0, "R10 flag cleared by read", rx_valid, 0);
        end

        // R5 + R11: back-to-back characters keep select low
        begin
            int r0, lc0, sn0;
            spi_mode = 2'd0; lsb_first = 1'b0; div_sel = 3'd2; inv = 1'b0;
            settle(3);
            r0 = ss_rises; lc0 = low_cnt; sn0 = slv_n;
            pulse_wr(8'h5A);
            while (tx_empty !== 1'b1) @(posedge clk);
            pulse_wr(8'hC3);
            wait_ss_high();
            check(ss_rises - r0 == 1, "R5 single ss release", ss_rises - r0, 1);
            check(low_cnt - lc0 == 34 * 4, "R5 continuous select", low_cnt - lc0, 136);
            check(slv_n - sn0 == 2, "R5 two chars", slv_n - sn0, 2);
            check(slv_bytes[sn0[5:0]] == 8'h5A, "R5 first char", slv_bytes[sn0[5:0]], 8'h5A);
            check(host_rdata == 8'hC3, "R11 latest byte shown", host_rdata, 8'hC3);
            check(rx_valid == 1'b1, "R10 flag stays through transfers", rx_valid, 1);
            pulse_rd();
            settle(3);
        end

        // R7 + R8 + R9: overflow and its clear
        begin
            int sn0;
            div_sel = 3'd3;
            settle(2);
            sn0 = slv_n;
            pulse_wr(8'h11);
            while (tx_empty !== 1'b1) @(posedge clk);
            pulse_wr(8'h22);
            #1;
            check(tx_empty == 1'b0, "R7 buffer full", tx_empty, 0);
            check(send_err == 1'b0, "R8 no error yet", send_err, 0);
            pulse_wr(8'h33);
            #1;
            check(send_err == 1'b1, "R8 overflow flagged", send_err, 1);
            wait_ss_high();
            check(slv_n - sn0 == 2, "R8 extra write dropped", slv_n - sn0, 2);
            check(slv_bytes[(sn0 + 1) % 64] == 8'h22, "R8 queued byte sent",
                  slv_bytes[(sn0 + 1) % 64], 8'h22);
            check(send_err == 1'b1, "R8 error sticky", send_err, 1);
            pulse_clr();
            settle(2);
            check(send_err == 1'b0, "R9 error cleared", send_err, 0);
            pulse_rd();
            settle(3);
        end

        // R12: sweep the read strobe across the completion cycle
        div_sel = 3'd0;
        for (int k = 6; k <= 14; k++) begin
            logic [7:0] b;
            b = 8'h40 + 8'(k);
            settle(2);
            pulse_wr(b);
            repeat (k) @(posedge clk);
            pulse_rd();
            wait_ss_high();
            check(host_rdata == b, "R12 new byte at collision sweep", host_rdata, b);
            if (k == 6)  check(rx_valid == 1'b1, "R12 read before completion", rx_valid, 1);
            if (k == 14) check(rx_valid == 1'b0, "R12 read after completion", rx_valid, 0);
            pulse_rd();
            settle(3);
            check(rx_valid == 1'b0, "R10 final read clears", rx_valid, 0);
        end

        finish_run();
    end

endmodule